// File: doc/BRIEF.md
# Tearing Sync Pulse Detector and Frame Start Trigger

This block watches the tearing-effect sync output of an external display panel and decides when a frame transfer to that panel may begin. The panel signals either over one combined pin, where horizontal and vertical pulses differ only in length, or over two separate pins, one per sync kind. Each pin goes through a synchronizer and a polarity stage. The block then measures how long the pin stays active and turns each finished pulse into a horizontal or vertical sync event.

Vertical events clear a line counter and horizontal events advance it. When the counter lands on a programmed line while a transfer is armed, the block raises a one-cycle start trigger. With tearing sync switched off, software arms the transfer and sets a start bit, and the hardware clears that bit once it has produced the trigger. After the trigger, a pixel budget loaded at arm time is counted down by pixel strobes from the data path. When the budget runs out, the enable drops and a one-cycle completion pulse is emitted.

Top module: `tear_sync_trigger`

## Requirements
- R1: After reset, `start_trig`, `xfer_en`, `xfer_done` and `start_pending` are 0, and `line_cnt` and `pix_left` are 0.
- R2: `sync_mode` is decoded as follows: 0 means tearing sync off, 1 means one combined pin on `te_a`, 2 means separate pins (`te_a` horizontal, `te_b` vertical), and 3 behaves like 0 for triggering and produces no sync events.
- R3: A set polarity bit makes the high level of its pin the active level, and a clear bit makes the low level active. `hs_active_high` governs `te_a` in both pin modes and `vs_active_high` governs `te_b`. A pulse's width is the number of clock cycles its pin holds the active level.
- R4: In one-pin mode, a finished pulse with width >= `vs_min_width` is vertical. A pulse with width >= `hs_min_width` but below `vs_min_width` is horizontal. Any shorter pulse is ignored.
- R5: Sync events are produced only when the thresholds are legal: `hs_min_width` >= 2, `vs_min_width` >= 4 in one-pin mode or >= 2 in two-pin mode, and the two thresholds differ. Otherwise `line_cnt` holds its value.
- R6: A vertical event sets `line_cnt` to 0. A horizontal event adds 1, saturating at 2047.
- R7: In modes 1 and 2, while a transfer is armed, a sync event that leaves `line_cnt` equal to `trig_line` (0..2047) raises `start_trig` for exactly one cycle, and the transfer moves to running.
- R8: In modes 0 and 3, a control write with `ctl_start` set raises `start_pending`. While armed, a pending start gives `start_trig` on the next cycle and clears `start_pending`. In modes 1 and 2, `ctl_start` is not latched.
- R9: A control write with `ctl_enable` set and a nonzero `pix_total` arms the transfer (`xfer_en` = 1) and loads `pix_left`. Only a running transfer decrements `pix_left` on `pix_tick`. When it reaches 0, `xfer_done` pulses for one cycle and `xfer_en` clears.
- R10: A control write with `ctl_enable` clear, or with `pix_total` equal to 0, leaves the transfer idle with `pix_left` = 0 and no `xfer_done`.
- R11: In two-pin mode, a `te_b` pulse with width >= `vs_min_width` is vertical and a `te_a` pulse with width >= `hs_min_width` is horizontal, with shorter pulses ignored. A vertical and a horizontal event in the same cycle leave `line_cnt` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 2 | Tearing sync mode (0 off, 1 one pin, 2 two pins, 3 off) |
| hs_active_high | input | 1 | Active level of the horizontal / combined pin |
| vs_active_high | input | 1 | Active level of the vertical pin |
| hs_min_width | input | CNT_W | Horizontal pulse width threshold in cycles |
| vs_min_width | input | CNT_W | Vertical pulse width threshold in cycles |
| trig_line | input | LINE_W | Line number at which the trigger fires |
| ctl_wr | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Enable value written by the control write |
| ctl_start | input | 1 | Software start bit written by the control write |
| pix_total | input | PIX_W | Pixel budget loaded when arming |
| pix_tick | input | 1 | One pixel consumed by the data path |
| te_a | input | 1 | Combined or horizontal tearing sync pin |
| te_b | input | 1 | Vertical tearing sync pin |
| start_trig | output | 1 | One-cycle frame start trigger |
| xfer_en | output | 1 | Transfer armed or running |
| xfer_done | output | 1 | One-cycle completion pulse |
| start_pending | output | 1 | Software start bit not yet consumed |
| line_cnt | output | LINE_W | Lines seen since the last vertical sync |
| pix_left | output | PIX_W | Pixels still to transfer |

## Verification
A pin level is sampled at a clock edge and then crosses two synchronizer flops and the width counter. The resulting `line_cnt` change, and any `start_trig` it causes, therefore appear after the third edge at which the pin is seen inactive. A control write or a `pix_tick` shows up on `xfer_en`, `pix_left`, `start_pending` and `xfer_done` after the single edge that samples it, and a pending software start needs one more edge to produce `start_trig`. The bench drives inputs on falling edges and keeps a behavioural model that advances on every rising edge with exactly these delays. On every falling edge, all six outputs are compared with that model. Directed checks read trigger and completion counts and `line_cnt` only after several idle cycles, once the three-edge path has settled.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

   typedef enum logic [1:0] {
      TS_OFF     = 2'd0,
      TS_ONE_PIN = 2'd1,
      TS_TWO_PIN = 2'd2,
      TS_RSVD    = 2'd3
   } ts_mode_e;

   typedef enum logic [1:0] {
      XF_IDLE  = 2'd0,
      XF_ARMED = 2'd1,
      XF_RUN   = 2'd2
   } xf_state_e;

   typedef struct packed {
      logic vert;
      logic horz;
   } sync_evt_t;

   function automatic logic mode_uses_sync(input logic [1:0] m);
      return (m == TS_ONE_PIN) || (m == TS_TWO_PIN);
   endfunction

endpackage

// File: rtl/tsync_in_sync.sv
module tsync_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic active_high,
   output logic active
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tsync_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign active = (chain_q[STAGES-1] == active_high);

endmodule

// File: rtl/tsync_width_meas.sv
module tsync_width_meas #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   output logic             pulse_end,
   output logic [CNT_W-1:0] width
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               run_q <= '0;
      else if (!active)         run_q <= '0;
      else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
   end

   assign pulse_end = !active && (run_q != '0);
   assign width     = run_q;

endmodule

// File: rtl/tsync_line_track.sv
module tsync_line_track
   import tsync_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [CNT_W-1:0]  hs_thr,
   input  logic [CNT_W-1:0]  vs_thr,
   input  logic [LINE_W-1:0] target,
   input  logic              end_a,
   input  logic [CNT_W-1:0]  width_a,
   input  logic              end_b,
   input  logic [CNT_W-1:0]  width_b,
   output logic [LINE_W-1:0] line_cnt,
   output logic              line_hit
);
   localparam logic [LINE_W-1:0] LINE_MAX   = {LINE_W{1'b1}};
   localparam logic [CNT_W-1:0]  HS_FLOOR   = CNT_W'(2);
   localparam logic [CNT_W-1:0]  VS_FLOOR_1 = CNT_W'(4);
   localparam logic [CNT_W-1:0]  VS_FLOOR_2 = CNT_W'(2);

   logic              thr_ok;
   sync_evt_t         evt;
   logic [LINE_W-1:0] line_q, line_d;

   always_comb begin
      thr_ok = 1'b0;
      unique case (mode)
         TS_ONE_PIN: thr_ok = (hs_thr >= HS_FLOOR) && (vs_thr >= VS_FLOOR_1)
                              && (hs_thr != vs_thr);
         TS_TWO_PIN: thr_ok = (hs_thr >= HS_FLOOR) && (vs_thr >= VS_FLOOR_2)
                              && (hs_thr != vs_thr);
         default:    thr_ok = 1'b0;
      endcase
   end

   always_comb begin
      evt = '0;
      if (thr_ok) begin
         if (mode == TS_ONE_PIN) begin
            if (end_a && (width_a >= vs_thr))      evt.vert = 1'b1;
            else if (end_a && (width_a >= hs_thr)) evt.horz = 1'b1;
         end else begin
            evt.vert = end_b && (width_b >= vs_thr);
            evt.horz = end_a && (width_a >= hs_thr);
         end
      end
   end

   always_comb begin
      line_d = line_q;
      if (evt.vert)                          line_d = '0;
      else if (evt.horz && line_q != LINE_MAX) line_d = line_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= '0;
      else        line_q <= line_d;
   end

   assign line_cnt = line_q;
   assign line_hit = (evt.vert || evt.horz) && (line_d == target);

endmodule

// File: rtl/tsync_xfer_ctrl.sv
module tsync_xfer_ctrl
   import tsync_pkg::*;
#(
   parameter int PIX_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             line_hit,
   input  logic             ctl_wr,
   input  logic             ctl_enable,
   input  logic             ctl_start,
   input  logic [PIX_W-1:0] pix_total,
   input  logic             pix_tick,
   output logic             start_trig,
   output logic             xfer_en,
   output logic             xfer_done,
   output logic             start_pending,
   output logic [PIX_W-1:0] pix_left
);
   xf_state_e        st_q;
   logic [PIX_W-1:0] left_q;
   logic             pend_q, trig_q, done_q;
   logic             sync_sel, fire;

   assign sync_sel = mode_uses_sync(mode);
   assign fire     = sync_sel ? line_hit : pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= XF_IDLE;
         left_q <= '0;
         pend_q <= 1'b0;
         trig_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         trig_q <= 1'b0;
         done_q <= 1'b0;
         if (ctl_wr) begin
            pend_q <= ctl_start && !sync_sel;
            if (ctl_enable && (pix_total != '0)) begin
               st_q   <= XF_ARMED;
               left_q <= pix_total;
            end else begin
               st_q   <= XF_IDLE;
               left_q <= '0;
            end
         end else begin
            unique case (st_q)
               XF_ARMED: begin
                  if (fire) begin
                     st_q   <= XF_RUN;
                     trig_q <= 1'b1;
                     pend_q <= 1'b0;
                  end
               end
               XF_RUN: begin
                  if (pix_tick) begin
                     left_q <= left_q - 1'b1;
                     if (left_q == PIX_W'(1)) begin
                        st_q   <= XF_IDLE;
                        done_q <= 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign start_trig    = trig_q;
   assign xfer_en       = (st_q != XF_IDLE);
   assign xfer_done     = done_q;
   assign start_pending = pend_q;
   assign pix_left      = left_q;

endmodule

// File: rtl/tear_sync_trigger.sv
module tear_sync_trigger
   import tsync_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int LINE_W      = 11,
   parameter int PIX_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter bit TWO_PIN_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        sync_mode,
   input  logic              hs_active_high,
   input  logic              vs_active_high,
   input  logic [CNT_W-1:0]  hs_min_width,
   input  logic [CNT_W-1:0]  vs_min_width,
   input  logic [LINE_W-1:0] trig_line,
   input  logic              ctl_wr,
   input  logic              ctl_enable,
   input  logic              ctl_start,
   input  logic [PIX_W-1:0]  pix_total,
   input  logic              pix_tick,
   input  logic              te_a,
   input  logic              te_b,
   output logic              start_trig,
   output logic              xfer_en,
   output logic              xfer_done,
   output logic              start_pending,
   output logic [LINE_W-1:0] line_cnt,
   output logic [PIX_W-1:0]  pix_left
);
   if (CNT_W < 3) begin : g_bad_cnt
      $error("tear_sync_trigger: CNT_W must hold a width of 4");
   end
   if (LINE_W < 1 || PIX_W < 1) begin : g_bad_w
      $error("tear_sync_trigger: LINE_W and PIX_W must be positive");
   end

   logic             act_a, end_a;
   logic [CNT_W-1:0] width_a;
   logic             end_b;
   logic [CNT_W-1:0] width_b;
   logic             line_hit;

   tsync_in_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
      .clk(clk), .rst_n(rst_n), .pin(te_a),
      .active_high(hs_active_high), .active(act_a)
   );
   tsync_width_meas #(.CNT_W(CNT_W)) u_meas_a (
      .clk(clk), .rst_n(rst_n), .active(act_a),
      .pulse_end(end_a), .width(width_a)
   );

   if (TWO_PIN_EN) begin : g_pin_b
      logic act_b;
      tsync_in_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
         .clk(clk), .rst_n(rst_n), .pin(te_b),
         .active_high(vs_active_high), .active(act_b)
      );
      tsync_width_meas #(.CNT_W(CNT_W)) u_meas_b (
         .clk(clk), .rst_n(rst_n), .active(act_b),
         .pulse_end(end_b), .width(width_b)
      );
   end else begin : g_no_pin_b
      logic unused_b;
      assign unused_b = te_b ^ vs_active_high;
      assign end_b    = 1'b0;
      assign width_b  = '0;
   end

   tsync_line_track #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_line (
      .clk(clk), .rst_n(rst_n), .mode(sync_mode),
      .hs_thr(hs_min_width), .vs_thr(vs_min_width), .target(trig_line),
      .end_a(end_a), .width_a(width_a), .end_b(end_b), .width_b(width_b),
      .line_cnt(line_cnt), .line_hit(line_hit)
   );

   tsync_xfer_ctrl #(.PIX_W(PIX_W)) u_xfer (
      .clk(clk), .rst_n(rst_n), .mode(sync_mode), .line_hit(line_hit),
      .ctl_wr(ctl_wr), .ctl_enable(ctl_enable), .ctl_start(ctl_start),
      .pix_total(pix_total), .pix_tick(pix_tick),
      .start_trig(start_trig), .xfer_en(xfer_en), .xfer_done(xfer_done),
      .start_pending(start_pending), .pix_left(pix_left)
   );

endmodule

// File: rtl/tear_sync_trigger_chk.sv
module tear_sync_trigger_chk #(
   parameter int LINE_W = 11,
   parameter int PIX_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_wr,
   input logic              start_trig,
   input logic              xfer_en,
   input logic              xfer_done,
   input logic [LINE_W-1:0] line_cnt,
   input logic [PIX_W-1:0]  pix_left
);
   // R7
   trig_while_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_trig |-> xfer_en);
   // R7
   trig_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_trig |=> !start_trig);
   // R9
   done_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> !xfer_en);
   // R9
   pix_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctl_wr) |-> (pix_left <= $past(pix_left)));
   // R6
   line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_cnt != $past(line_cnt)) |->
         ((line_cnt == '0) || (line_cnt == $past(line_cnt) + 1'b1)));
   // R9
   trig_done_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_trig && xfer_done));
endmodule

bind tear_sync_trigger tear_sync_trigger_chk #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .start_trig(start_trig),
   .xfer_en(xfer_en), .xfer_done(xfer_done), .line_cnt(line_cnt),
   .pix_left(pix_left)
);

// File: tb/tear_sync_trigger_tb.sv
module tear_sync_trigger_tb;
   localparam int CNT_W  = 8;
   localparam int LINE_W = 11;
   localparam int PIX_W  = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] sync_mode = 2'd0;
   logic hs_active_high = 1'b1, vs_active_high = 1'b1;
   logic [CNT_W-1:0] hs_min_width = 8'd3, vs_min_width = 8'd6;
   logic [LINE_W-1:0] trig_line = '0;
   logic ctl_wr = 0, ctl_enable = 0, ctl_start = 0, pix_tick = 0;
   logic [PIX_W-1:0] pix_total = '0;
   logic te_a = 0, te_b = 0;
   logic start_trig, xfer_en, xfer_done, start_pending;
   logic [LINE_W-1:0] line_cnt;
   logic [PIX_W-1:0] pix_left;

   int n_tests = 0, n_fail = 0;
   int trig_seen = 0, done_seen = 0;

   always #5 clk = ~clk;

   tear_sync_trigger #(.CNT_W(CNT_W), .LINE_W(LINE_W), .PIX_W(PIX_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
      .hs_active_high(hs_active_high), .vs_active_high(vs_active_high),
      .hs_min_width(hs_min_width), .vs_min_width(vs_min_width),
      .trig_line(trig_line), .ctl_wr(ctl_wr), .ctl_enable(ctl_enable),
      .ctl_start(ctl_start), .pix_total(pix_total), .pix_tick(pix_tick),
      .te_a(te_a), .te_b(te_b), .start_trig(start_trig), .xfer_en(xfer_en),
      .xfer_done(xfer_done), .start_pending(start_pending),
      .line_cnt(line_cnt), .pix_left(pix_left)
   );

   // behavioural reference model
   int m_pa1, m_pa2, m_pb1, m_pb2, run_a, run_b, m_line, m_st, m_left;
   bit m_pend, m_trig, m_done;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pa1 = 0; m_pa2 = 0; m_pb1 = 0; m_pb2 = 0; run_a = 0; run_b = 0;
         m_line = 0; m_st = 0; m_left = 0; m_pend = 0; m_trig = 0; m_done = 0;
      end else begin
         bit act_a, act_b, ea, eb, ok, vse, hse, hit, sy, fire;
         int wa, wb;
         act_a = (m_pa2 == int'(hs_active_high));
         act_b = (m_pb2 == int'(vs_active_high));
         ea = !act_a && run_a > 0; wa = run_a;
         eb = !act_b && run_b > 0; wb = run_b;
         run_a = act_a ? ((run_a < 255) ? run_a + 1 : 255) : 0;
         run_b = act_b ? ((run_b < 255) ? run_b + 1 : 255) : 0;
         m_pa2 = m_pa1; m_pa1 = int'(te_a);
         m_pb2 = m_pb1; m_pb1 = int'(te_b);
         sy = (sync_mode == 2'd1) || (sync_mode == 2'd2);
         ok = 0;
         if (sync_mode == 2'd1)
            ok = hs_min_width >= 2 && vs_min_width >= 4 && hs_min_width != vs_min_width;
         if (sync_mode == 2'd2)
            ok = hs_min_width >= 2 && vs_min_width >= 2 && hs_min_width != vs_min_width;
         vse = 0; hse = 0;
         if (ok && sync_mode == 2'd1 && ea) begin
            if (wa >= int'(vs_min_width)) vse = 1;
            else if (wa >= int'(hs_min_width)) hse = 1;
         end
         if (ok && sync_mode == 2'd2) begin
            vse = eb && wb >= int'(vs_min_width);
            hse = ea && wa >= int'(hs_min_width);
         end
         if (vse) m_line = 0;
         else if (hse && m_line < 2047) m_line = m_line + 1;
         hit = (vse || hse) && m_line == int'(trig_line);
         m_trig = 0; m_done = 0;
         if (ctl_wr) begin
            m_pend = ctl_start && !sy;
            if (ctl_enable && pix_total != 0) begin m_st = 1; m_left = int'(pix_total); end
            else begin m_st = 0; m_left = 0; end
         end else if (m_st == 1) begin
            fire = sy ? hit : m_pend;
            if (fire) begin m_st = 2; m_trig = 1; m_pend = 0; end
         end else if (m_st == 2 && pix_tick) begin
            if (m_left == 1) begin m_st = 0; m_done = 1; end
            m_left = m_left - 1;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (start_trig) trig_seen++;
         if (xfer_done) done_seen++;
         chk("R7", "start_trig", int'(start_trig), int'(m_trig));
         chk("R9", "xfer_en", int'(xfer_en), int'(m_st != 0));
         chk("R9", "xfer_done", int'(xfer_done), int'(m_done));
         chk("R8", "start_pending", int'(start_pending), int'(m_pend));
         chk("R6", "line_cnt", int'(line_cnt), m_line);
         chk("R9", "pix_left", int'(pix_left), m_left);
      end
   end

   task automatic idle(input int n); repeat (n) @(negedge clk); endtask
   task automatic ctl(input bit en, input bit st, input int pix);
      @(negedge clk); ctl_wr = 1; ctl_enable = en; ctl_start = st; pix_total = PIX_W'(pix);
      @(negedge clk); ctl_wr = 0; ctl_enable = 0; ctl_start = 0;
   endtask
   task automatic ticks(input int n);
      @(negedge clk); pix_tick = 1; repeat (n) @(negedge clk); pix_tick = 0;
   endtask
   task automatic pulse(input bit on_a, input bit on_b, input int n);
      @(negedge clk);
      if (on_a) te_a = hs_active_high;
      if (on_b) te_b = vs_active_high;
      repeat (n) @(negedge clk);
      te_a = !hs_active_high; te_b = !vs_active_high;
      idle(5);
   endtask

   initial begin
      #2000000;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int t0, d0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "reset xfer_en", int'(xfer_en), 0);
      chk("R1", "reset line_cnt", int'(line_cnt), 0);
      chk("R1", "reset pix_left", int'(pix_left), 0);
      chk("R1", "reset start_pending", int'(start_pending), 0);

      // R8 R9 software start
      t0 = trig_seen; d0 = done_seen;
      ctl(1, 1, 5); idle(2);
      chk("R8", "sw trigger count", trig_seen - t0, 1);
      chk("R8", "start bit cleared", int'(start_pending), 0);
      ticks(5); idle(2);
      chk("R9", "done count", done_seen - d0, 1);
      chk("R9", "enable dropped", int'(xfer_en), 0);

      // R9 ticks while armed ignored, R10 abort and zero count
      ctl(1, 0, 3); ticks(4); idle(1);
      chk("R9", "armed ignores ticks", int'(pix_left), 3);
      d0 = done_seen;
      ctl(0, 0, 3); idle(2);
      chk("R10", "abort clears enable", int'(xfer_en), 0);
      chk("R10", "abort no done", done_seen - d0, 0);
      ctl(1, 0, 0); idle(1);
      chk("R10", "zero count stays idle", int'(xfer_en), 0);

      // one-pin mode, R4 R7
      sync_mode = 2'd1; hs_min_width = 3; vs_min_width = 6; trig_line = 2;
      idle(4);
      ctl(1, 1, 4); idle(1);
      chk("R8", "start bit not latched in sync mode", int'(start_pending), 0);
      t0 = trig_seen;
      pulse(1, 0, 6);
      chk("R4", "vertical at threshold", int'(line_cnt), 0);
      pulse(1, 0, 3);
      chk("R4", "horizontal at threshold", int'(line_cnt), 1);
      pulse(1, 0, 2);
      chk("R4", "short pulse ignored", int'(line_cnt), 1);
      chk("R7", "no trigger before line", trig_seen - t0, 0);
      pulse(1, 0, 5);
      chk("R7", "trigger at programmed line", trig_seen - t0, 1);
      chk("R6", "line after two horizontals", int'(line_cnt), 2);
      ticks(4); idle(2);
      pulse(1, 0, 9);
      chk("R6", "vertical clears line", int'(line_cnt), 0);

      // R3 active-low polarity
      hs_active_high = 0; te_a = 1; idle(6);
      pulse(1, 0, 4); pulse(1, 0, 4);
      chk("R3", "low-active pulses counted", int'(line_cnt), 2);
      hs_active_high = 1; te_a = 0; idle(6);
      pulse(1, 0, 8);
      chk("R3", "back to high-active vertical", int'(line_cnt), 0);

      // R5 illegal thresholds
      hs_min_width = 3; vs_min_width = 3; idle(2);
      pulse(1, 0, 4);
      chk("R5", "equal thresholds no events", int'(line_cnt), 0);
      hs_min_width = 2; vs_min_width = 3; idle(2);
      pulse(1, 0, 2);
      chk("R5", "one-pin vertical below 4 no events", int'(line_cnt), 0);

      // two-pin mode, R11, trigger at line 0
      sync_mode = 2'd2; trig_line = 0; idle(2);
      pulse(1, 0, 2);
      chk("R5", "two-pin accepts vertical 3", int'(line_cnt), 1);
      ctl(1, 0, 2); t0 = trig_seen;
      pulse(0, 1, 3);
      chk("R11", "vertical pin clears line", int'(line_cnt), 0);
      chk("R7", "trigger on line 0", trig_seen - t0, 1);
      ticks(2); idle(2);
      pulse(1, 0, 2); pulse(1, 0, 2);
      pulse(0, 1, 2);
      chk("R11", "short vertical ignored", int'(line_cnt), 2);
      pulse(1, 1, 3);
      chk("R11", "simultaneous events vertical wins", int'(line_cnt), 0);

      // R2 mode 3 is off
      sync_mode = 2'd3; idle(2);
      t0 = trig_seen;
      ctl(1, 0, 1); trig_line = 1;
      pulse(1, 0, 4);
      chk("R2", "reserved mode no sync trigger", trig_seen - t0, 0);
      chk("R2", "reserved mode no line events", int'(line_cnt), 0);
      ctl(1, 1, 1); idle(2);
      chk("R2", "reserved mode software start", trig_seen - t0, 1);
      ticks(1); idle(2);

      // R6 saturation
      sync_mode = 2'd1; hs_min_width = 2; vs_min_width = 4; idle(2);
      for (int i = 0; i < 2060; i++) begin
         @(negedge clk); te_a = 1; repeat (2) @(negedge clk); te_a = 0;
         repeat (2) @(negedge clk);
      end
      idle(6);
      chk("R6", "line saturates at 2047", int'(line_cnt), 2047);

      idle(3);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule